// File: doc/BRIEF.md
# Shared Memory Ring Buffer Client

This block lets local logic exchange a byte stream with a processor through ring buffers that sit in that processor's memory. Each ring is described in shared memory by a small header: a size mask (the ring length minus one, so the length is a power of two), a producer index, a consumer index, and then the data bytes. The block keeps a local copy of each ring's base address, mask and indices. It reaches the remote memory only through a simple bus request channel: bus ownership requests, ownership release, and single byte reads and writes.

A caller issues one command at a time: init a ring, ask whether it is empty or full, take one byte without waiting, or put one byte and wait for space. Every command that touches memory is enclosed in one bus ownership. Each command returns a result flag, an error flag and, for a take, the byte. Up to four rings are kept apart by a ring select, and each ring has its own cached state.

Top module: `shring_client`

## Requirements
- R1: After a synchronous active-low reset the block is idle (`cmd_ready`=1, `rsp_valid`=0, `bus_req_valid`=0), and every ring is marked unused (base zero).
- R2: Command codes on `cmd_op` are 0 init, 1 empty test, 2 full test, 3 take, 4 put. Bus request kinds on `bus_req_kind` are 0 acquire, 1 release, 2 read, 3 write. An init with a nonzero base acquires the bus and reads the mask at base+0, the producer index at base+1 and the consumer index at base+2. It then releases the bus and reports flag 1. An init with base zero marks the ring unused, uses no bus cycle and reports flag 0.
- R3: An empty test reads the remote producer index and reports flag 1 when it equals the cached consumer index. An unused ring reports empty and uses no bus cycle.
- R4: A full test reads the remote consumer index and reports flag 1 when (cached producer index + 1) AND mask equals it. An unused ring reports not full.
- R5: A take on a non-empty ring reads the byte at base+3+consumer index, advances the consumer index modulo mask+1 and writes it to base+2, all under one ownership. It reports flag 1 and the byte on `rsp_data`. The bus is released before the response.
- R6: A take on an empty or unused ring reports flag 0 and leaves the cached consumer index unchanged.
- R7: A put writes the byte at base+3+producer index, advances the producer index under the mask, writes it to base+1 and reports flag 1. A put to an unused ring reports flag 0 and uses no bus cycle.
- R8: A put to a full ring releases the bus and retries the acquire and the full test until space appears. It then completes as in R7.
- R9: When an acquire is refused (`bus_ok`=0 on its completion), the command ends with `rsp_err`=1 and flag 0. No release is issued and no cached base, mask or index changes.
- R10: The four rings are independent. A command changes only the cached state of the ring chosen by `cmd_ring`.
- R11: Only one bus request is outstanding at a time, and the controller answers it at least one cycle later with `bus_done`. Reads, writes and releases are issued only while the bus is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered; taken when `cmd_ready` is high |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 3 | Command code (R2) |
| cmd_ring | input | 2 | Ring select |
| cmd_base | input | 16 | Header base address for init |
| cmd_data | input | 8 | Byte for put |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_flag | output | 1 | Result: active, empty, full or transfer done |
| rsp_err | output | 1 | Bus acquire refused |
| rsp_data | output | 8 | Byte taken by a take |
| bus_req_valid | output | 1 | One-cycle bus request strobe |
| bus_req_kind | output | 2 | Acquire, release, read or write (R2) |
| bus_req_addr | output | 16 | Memory address for read or write |
| bus_req_wdata | output | 8 | Write byte |
| bus_done | input | 1 | Completion of the outstanding request |
| bus_ok | input | 1 | Acquire granted (valid with `bus_done`) |
| bus_rdata | input | 8 | Read byte (valid with `bus_done`) |

## Verification
The hardest case to reach from the ports is the put retry loop, where the block must release ownership and come back while the remote consumer index is still unchanged. The bench's memory model counts acquire requests. It advances the consumer index in memory only at a chosen acquire, so the ring stays full for a known number of rounds. A refused acquire is caused in the same model. Later puts then show that the cached producer index was not moved.

// File: rtl/shring_pkg.sv
// Shared definitions for the ring client: command codes, bus request
// kinds and the fixed layout of a ring header in remote memory.
package shring_pkg;
    typedef enum logic [2:0] {
        OP_INIT  = 3'd0,
        OP_EMPTY = 3'd1,
        OP_FULL  = 3'd2,
        OP_GET   = 3'd3,
        OP_PUT   = 3'd4
    } ring_op_e;

    typedef enum logic [1:0] {
        BK_ACQ = 2'd0,
        BK_REL = 2'd1,
        BK_RD  = 2'd2,
        BK_WR  = 2'd3
    } bus_kind_e;

    localparam int HDR_MASK_OFS = 0;
    localparam int HDR_PROD_OFS = 1;
    localparam int HDR_CONS_OFS = 2;
    localparam int HDR_DATA_OFS = 3;
endpackage

// File: rtl/shring_cache.sv
// Per-ring local state: base, mask, producer and consumer index.
// Assumes one whole-entry write at a time; the read port is combinational.
module shring_cache #(
    parameter int NRINGS = 4,
    parameter int AW     = 16,
    localparam int SW    = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_sel,
    output logic [AW-1:0] rd_base,
    output logic [7:0]    rd_mask,
    output logic [7:0]    rd_prod,
    output logic [7:0]    rd_cons,
    input  logic          we,
    input  logic [SW-1:0] wr_sel,
    input  logic [AW-1:0] wr_base,
    input  logic [7:0]    wr_mask,
    input  logic [7:0]    wr_prod,
    input  logic [7:0]    wr_cons
);
    logic [AW-1:0] base_q [NRINGS];
    logic [7:0]    mask_q [NRINGS];
    logic [7:0]    prod_q [NRINGS];
    logic [7:0]    cons_q [NRINGS];

    for (genvar g = 0; g < NRINGS; g++) begin : g_entry
        // Hold one ring's entry; load it when this ring is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                mask_q[g] <= '0;
                prod_q[g] <= '0;
                cons_q[g] <= '0;
            end else if (we && wr_sel == SW'(g)) begin
                base_q[g] <= wr_base;
                mask_q[g] <= wr_mask;
                prod_q[g] <= wr_prod;
                cons_q[g] <= wr_cons;
            end
        end
    end

    // Present the selected ring's entry.
    always_comb begin
        rd_base = base_q[rd_sel];
        rd_mask = mask_q[rd_sel];
        rd_prod = prod_q[rd_sel];
        rd_cons = cons_q[rd_sel];
    end
endmodule

// File: rtl/shring_seq.sv
// Command sequencer: runs each command as acquire, header and data
// accesses, release, then response. It works on a private copy of the
// ring entry and commits it only when the command ends without a refused
// acquire. Assumes the bus controller answers each request a cycle or more
// later.
module shring_seq
    import shring_pkg::*;
#(
    parameter int NRINGS = 4,
    parameter int AW     = 16,
    localparam int SW    = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_ring,
    input  logic [AW-1:0] cmd_base,
    input  logic [7:0]    cmd_data,
    output logic          rsp_valid,
    output logic          rsp_flag,
    output logic          rsp_err,
    output logic [7:0]    rsp_data,
    output logic [SW-1:0] c_rd_sel,
    input  logic [AW-1:0] c_base,
    input  logic [7:0]    c_mask,
    input  logic [7:0]    c_prod,
    input  logic [7:0]    c_cons,
    output logic          c_we,
    output logic [SW-1:0] c_wr_sel,
    output logic [AW-1:0] c_wr_base,
    output logic [7:0]    c_wr_mask,
    output logic [7:0]    c_wr_prod,
    output logic [7:0]    c_wr_cons,
    output logic          bus_req_valid,
    output logic [1:0]    bus_req_kind,
    output logic [AW-1:0] bus_req_addr,
    output logic [7:0]    bus_req_wdata,
    input  logic          bus_done,
    input  logic          bus_ok,
    input  logic [7:0]    bus_rdata
);
    typedef enum logic [3:0] {
        S_IDLE, S_ACQ, S_RMASK, S_RPROD, S_RCONS,
        S_RDATA, S_WDATA, S_WIDX, S_REL, S_RESP
    } seq_state_e;

    seq_state_e    state;
    ring_op_e      op_q;
    logic [SW-1:0] ring_q;
    logic [7:0]    data_q;
    logic [AW-1:0] w_base;
    logic [7:0]    w_mask, w_prod, w_cons, rdat_q;
    logic          pend, owned, retry, commit, flag_q, err_q;
    logic [7:0]    prod_nxt, cons_nxt;
    logic          step;

    assign prod_nxt = (w_prod + 8'd1) & w_mask;
    assign cons_nxt = (w_cons + 8'd1) & w_mask;
    assign step     = (state != S_IDLE) && (state != S_RESP);

    assign cmd_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);
    assign rsp_flag  = flag_q;
    assign rsp_err   = err_q;
    assign rsp_data  = rdat_q;

    assign c_rd_sel  = cmd_ring;
    assign c_we      = (state == S_RESP) && commit;
    assign c_wr_sel  = ring_q;
    assign c_wr_base = w_base;
    assign c_wr_mask = w_mask;
    assign c_wr_prod = w_prod;
    assign c_wr_cons = w_cons;

    // Form the bus request for the current step; one per step.
    always_comb begin
        bus_req_valid = step && !pend;
        bus_req_kind  = BK_RD;
        bus_req_addr  = '0;
        bus_req_wdata = '0;
        case (state)
            S_ACQ:   bus_req_kind = BK_ACQ;
            S_REL:   bus_req_kind = BK_REL;
            S_RMASK: bus_req_addr = w_base + AW'(HDR_MASK_OFS);
            S_RPROD: bus_req_addr = w_base + AW'(HDR_PROD_OFS);
            S_RCONS: bus_req_addr = w_base + AW'(HDR_CONS_OFS);
            S_RDATA: bus_req_addr = w_base + AW'(HDR_DATA_OFS) + AW'(w_cons);
            S_WDATA: begin
                bus_req_kind  = BK_WR;
                bus_req_addr  = w_base + AW'(HDR_DATA_OFS) + AW'(w_prod);
                bus_req_wdata = data_q;
            end
            S_WIDX: begin
                bus_req_kind = BK_WR;
                if (op_q == OP_GET) begin
                    bus_req_addr  = w_base + AW'(HDR_CONS_OFS);
                    bus_req_wdata = w_cons;
                end else begin
                    bus_req_addr  = w_base + AW'(HDR_PROD_OFS);
                    bus_req_wdata = w_prod;
                end
            end
            default: ;
        endcase
    end

    // Step the command sequence and track ownership and the outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_INIT;
            ring_q <= '0;
            data_q <= '0;
            w_base <= '0;
            w_mask <= '0;
            w_prod <= '0;
            w_cons <= '0;
            rdat_q <= '0;
            pend   <= 1'b0;
            owned  <= 1'b0;
            retry  <= 1'b0;
            commit <= 1'b0;
            flag_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (bus_req_valid)
                pend <= 1'b1;
            else if (bus_done)
                pend <= 1'b0;
            case (state)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= ring_op_e'(cmd_op);
                    ring_q <= cmd_ring;
                    data_q <= cmd_data;
                    w_base <= c_base;
                    w_mask <= c_mask;
                    w_prod <= c_prod;
                    w_cons <= c_cons;
                    rdat_q <= '0;
                    flag_q <= 1'b0;
                    err_q  <= 1'b0;
                    retry  <= 1'b0;
                    commit <= 1'b0;
                    if (cmd_op == OP_INIT) begin
                        w_base <= cmd_base;
                        if (cmd_base == '0) begin
                            w_mask <= '0;
                            w_prod <= '0;
                            w_cons <= '0;
                            commit <= 1'b1;
                            state  <= S_RESP;
                        end else begin
                            state <= S_ACQ;
                        end
                    end else if (c_base == '0) begin
                        flag_q <= (cmd_op == OP_EMPTY);
                        state  <= S_RESP;
                    end else begin
                        state <= S_ACQ;
                    end
                end
                S_ACQ: if (bus_done) begin
                    if (bus_ok) begin
                        owned <= 1'b1;
                        case (op_q)
                            OP_INIT:          state <= S_RMASK;
                            OP_EMPTY, OP_GET: state <= S_RPROD;
                            OP_FULL, OP_PUT:  state <= S_RCONS;
                            default:          state <= S_REL;
                        endcase
                    end else begin
                        err_q <= 1'b1;
                        state <= S_RESP;
                    end
                end
                S_RMASK: if (bus_done) begin
                    w_mask <= bus_rdata;
                    state  <= S_RPROD;
                end
                S_RPROD: if (bus_done) begin
                    case (op_q)
                        OP_INIT: begin
                            w_prod <= bus_rdata;
                            state  <= S_RCONS;
                        end
                        OP_EMPTY: begin
                            flag_q <= (bus_rdata == w_cons);
                            state  <= S_REL;
                        end
                        OP_GET: state <= (bus_rdata == w_cons) ? S_REL : S_RDATA;
                        default: state <= S_REL;
                    endcase
                end
                S_RCONS: if (bus_done) begin
                    case (op_q)
                        OP_INIT: begin
                            w_cons <= bus_rdata;
                            flag_q <= 1'b1;
                            state  <= S_REL;
                        end
                        OP_FULL: begin
                            flag_q <= (prod_nxt == bus_rdata);
                            state  <= S_REL;
                        end
                        OP_PUT: begin
                            if (prod_nxt == bus_rdata) begin
                                retry <= 1'b1;
                                state <= S_REL;
                            end else begin
                                state <= S_WDATA;
                            end
                        end
                        default: state <= S_REL;
                    endcase
                end
                S_RDATA: if (bus_done) begin
                    rdat_q <= bus_rdata;
                    w_cons <= cons_nxt;
                    flag_q <= 1'b1;
                    state  <= S_WIDX;
                end
                S_WDATA: if (bus_done) begin
                    w_prod <= prod_nxt;
                    flag_q <= 1'b1;
                    state  <= S_WIDX;
                end
                S_WIDX: if (bus_done) state <= S_REL;
                S_REL: if (bus_done) begin
                    owned <= 1'b0;
                    if (retry) begin
                        retry <= 1'b0;
                        state <= S_ACQ;
                    end else begin
                        commit <= 1'b1;
                        state  <= S_RESP;
                    end
                end
                S_RESP: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory cycles only while the bus is owned.
    assert_mem_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && (bus_req_kind == BK_RD || bus_req_kind == BK_WR)) |-> owned);
    // A release is only issued for an ownership actually held.
    assert_rel_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_kind == BK_REL) |-> owned);
    // A request strobe is never followed directly by another.
    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |=> !bus_req_valid);
    // A refused acquire never reaches the cached state.
    assert_abort_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !c_we);
    // Ownership has been given back by the time a response appears.
    assert_released_at_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !owned);
endmodule

// File: rtl/shring_client.sv
// Top of the shared-memory ring client: a per-ring state cache and the
// command sequencer that reaches remote memory through the bus channel.
// Assumes one command at a time and one outstanding bus request.
module shring_client #(
    parameter int NRINGS = 4,
    parameter int AW     = 16,
    localparam int SW    = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_ring,
    input  logic [AW-1:0] cmd_base,
    input  logic [7:0]    cmd_data,
    output logic          rsp_valid,
    output logic          rsp_flag,
    output logic          rsp_err,
    output logic [7:0]    rsp_data,
    output logic          bus_req_valid,
    output logic [1:0]    bus_req_kind,
    output logic [AW-1:0] bus_req_addr,
    output logic [7:0]    bus_req_wdata,
    input  logic          bus_done,
    input  logic          bus_ok,
    input  logic [7:0]    bus_rdata
);
    logic [SW-1:0] rd_sel, wr_sel;
    logic [AW-1:0] rd_base, wr_base;
    logic [7:0]    rd_mask, rd_prod, rd_cons;
    logic [7:0]    wr_mask, wr_prod, wr_cons;
    logic          we;

    shring_cache #(.NRINGS(NRINGS), .AW(AW)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .rd_sel(rd_sel), .rd_base(rd_base), .rd_mask(rd_mask),
        .rd_prod(rd_prod), .rd_cons(rd_cons),
        .we(we), .wr_sel(wr_sel), .wr_base(wr_base), .wr_mask(wr_mask),
        .wr_prod(wr_prod), .wr_cons(wr_cons)
    );

    shring_seq #(.NRINGS(NRINGS), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_ring(cmd_ring), .cmd_base(cmd_base), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_err(rsp_err),
        .rsp_data(rsp_data),
        .c_rd_sel(rd_sel), .c_base(rd_base), .c_mask(rd_mask),
        .c_prod(rd_prod), .c_cons(rd_cons),
        .c_we(we), .c_wr_sel(wr_sel), .c_wr_base(wr_base),
        .c_wr_mask(wr_mask), .c_wr_prod(wr_prod), .c_wr_cons(wr_cons),
        .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_done(bus_done), .bus_ok(bus_ok), .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/sim_shring_client.sv
`timescale 1ns/1ps
module sim_shring_client;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_ring = '0;
    logic [15:0] cmd_base = '0;
    logic [7:0]  cmd_data = '0;
    logic        rsp_valid, rsp_flag, rsp_err;
    logic [7:0]  rsp_data;
    logic        bus_req_valid;
    logic [1:0]  bus_req_kind;
    logic [15:0] bus_req_addr;
    logic [7:0]  bus_req_wdata;
    logic        bus_done = 1'b0;
    logic        bus_ok = 1'b0;
    logic [7:0]  bus_rdata = '0;

    logic [7:0]  mem [0:511];
    int          acq_cnt = 0;
    int          rel_cnt = 0;
    int          poll_target = -1;
    logic        deny = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        r_flag, r_err;
    logic [7:0]  r_data;

    always #4 clk = ~clk;

    shring_client u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_ring(cmd_ring), .cmd_base(cmd_base),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_flag(rsp_flag),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .bus_req_valid(bus_req_valid),
        .bus_req_kind(bus_req_kind), .bus_req_addr(bus_req_addr),
        .bus_req_wdata(bus_req_wdata), .bus_done(bus_done), .bus_ok(bus_ok),
        .bus_rdata(bus_rdata)
    );

    // Bus controller and memory model: answers each request one cycle later.
    always @(posedge clk) begin
        bus_done <= 1'b0;
        if (bus_req_valid) begin
            bus_done <= 1'b1;
            bus_ok   <= 1'b1;
            case (bus_req_kind)
                2'd0: begin
                    bus_ok  <= !deny;
                    acq_cnt <= acq_cnt + 1;
                    if (acq_cnt + 1 == poll_target) mem[9'h0C2] = 8'd1;
                end
                2'd1: rel_cnt <= rel_cnt + 1;
                2'd2: bus_rdata <= mem[bus_req_addr[8:0]];
                default: mem[bus_req_addr[8:0]] = bus_req_wdata;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [1:0] ring,
                         input logic [15:0] base, input logic [7:0] data);
        int n;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ring = ring;
        cmd_base = base; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) chk("R11 response timeout", 0, 1);
        r_flag = rsp_flag; r_err = rsp_err; r_data = rsp_data;
    endtask

    function automatic string op_tag(input logic [2:0] op, input logic ef);
        case (op)
            3'd0: return "R2 init";
            3'd1: return "R3 empty";
            3'd2: return "R4 full";
            3'd3: return ef ? "R5 take" : "R6 take-empty";
            default: return "R7 put";
        endcase
    endfunction

    // {op, ring, base, data, exp_flag, exp_err, exp_data}; rings 0/1 also exercise R10
    localparam logic [38:0] VEC [0:23] = '{
        {3'd0, 2'd0, 16'h0040, 8'h00, 1'b1, 1'b0, 8'h00},
        {3'd0, 2'd1, 16'h0080, 8'h00, 1'b1, 1'b0, 8'h00},
        {3'd0, 2'd2, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd1, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd1, 2'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00},
        {3'd1, 2'd2, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00},
        {3'd2, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd2, 2'd2, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'hA0},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'hA1},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd3, 2'd2, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd4, 2'd1, 16'h0000, 8'h55, 1'b1, 1'b0, 8'h00},
        {3'd1, 2'd1, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd3, 2'd1, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h55},
        {3'd4, 2'd0, 16'h0000, 8'h11, 1'b1, 1'b0, 8'h00},
        {3'd4, 2'd0, 16'h0000, 8'h12, 1'b1, 1'b0, 8'h00},
        {3'd4, 2'd0, 16'h0000, 8'h13, 1'b1, 1'b0, 8'h00},
        {3'd2, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h00},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h11},
        {3'd2, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h12},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0, 8'h13},
        {3'd3, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0, 8'h00}
    };

    initial begin
        int a0;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[9'h040] = 8'd3; mem[9'h041] = 8'd2; mem[9'h042] = 8'd0;
        mem[9'h043] = 8'hA0; mem[9'h044] = 8'hA1;
        mem[9'h045] = 8'hA2; mem[9'h046] = 8'hA3;
        mem[9'h080] = 8'd7;
        mem[9'h0C0] = 8'd1; mem[9'h0C1] = 8'd1; mem[9'h0C2] = 8'd0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, rings unused
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 bus_req_valid", bus_req_valid, 0);
        a0 = acq_cnt;
        do_op(3'd1, 2'd0, 16'h0, 8'h0);
        chk("R1 empty on unused ring", r_flag, 1);
        chk("R1 no bus use before init", acq_cnt - a0, 0);

        for (int i = 0; i < 24; i++) begin
            do_op(VEC[i][38:36], VEC[i][35:34], VEC[i][33:18], VEC[i][17:10]);
            chk($sformatf("%s vec%0d flag", op_tag(VEC[i][38:36], VEC[i][9]), i),
                r_flag, VEC[i][9]);
            chk($sformatf("%s vec%0d err", op_tag(VEC[i][38:36], VEC[i][9]), i),
                r_err, VEC[i][8]);
            if (VEC[i][38:36] == 3'd3 && VEC[i][9])
                chk($sformatf("%s vec%0d data", op_tag(3'd3, 1'b1), i),
                    r_data, VEC[i][7:0]);
        end

        // R5 and R7: indices written back to the header
        chk("R5 consumer index in memory", mem[9'h042], 8'd1);
        chk("R7 producer index in memory", mem[9'h041], 8'd1);
        chk("R7 put byte in memory", mem[9'h083], 8'h55);

        // R9: refused acquire on a put
        deny = 1'b1;
        a0 = rel_cnt;
        do_op(3'd4, 2'd1, 16'h0, 8'h66);
        chk("R9 err on refused acquire", r_err, 1);
        chk("R9 flag on refused acquire", r_flag, 0);
        chk("R9 no release after refusal", rel_cnt - a0, 0);
        deny = 1'b0;
        do_op(3'd4, 2'd1, 16'h0, 8'h66);
        chk("R9 put after refusal flag", r_flag, 1);
        chk("R9 producer index kept", mem[9'h084], 8'h66);
        chk("R9 producer written", mem[9'h081], 8'd2);

        // R9: refused init keeps ring unused
        deny = 1'b1;
        do_op(3'd0, 2'd3, 16'h00C0, 8'h0);
        chk("R9 init refused err", r_err, 1);
        deny = 1'b0;
        a0 = acq_cnt;
        do_op(3'd1, 2'd3, 16'h0, 8'h0);
        chk("R9 ring still unused", r_flag, 1);
        chk("R9 unused ring no bus", acq_cnt - a0, 0);

        // R7: put to unused ring
        a0 = acq_cnt;
        do_op(3'd4, 2'd2, 16'h0, 8'h99);
        chk("R7 put unused flag", r_flag, 0);
        chk("R7 put unused no bus", acq_cnt - a0, 0);

        // R8: blocking put on a full ring, space appears on third acquire
        do_op(3'd0, 2'd3, 16'h00C0, 8'h0);
        chk("R8 init ring3", r_flag, 1);
        a0 = acq_cnt;
        poll_target = acq_cnt + 3;
        do_op(3'd4, 2'd3, 16'h0, 8'h77);
        chk("R8 put after wait flag", r_flag, 1);
        chk("R8 acquire rounds", acq_cnt - a0, 3);
        chk("R8 byte written", mem[9'h0C4], 8'h77);
        chk("R8 producer wrapped", mem[9'h0C1], 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule